// File: doc/BRIEF.md
# Turbo Sub-Block Interleaver Address Generator

This block turns a block of K coded bits, stored row by row in a 32-column matrix, into the column-wise interleaved order that feeds circular-buffer rate matching. After a start pulse that carries K and a mode, it emits one storage address per clock cycle, in output order, with a valid flag and a last flag. It does not store bits. A storage array next to it reads or writes at the given addresses.

Two orderings are supported. The first serves the systematic stream and the first parity stream. The second serves the second parity stream and shifts every address by one, modulo K. The column order is a 5-bit bit reversal of the column counter, so no table is stored. The modulo-K step is a single compare and conditional subtract, because its operand never reaches 2K.

Top module: `sbi_addr_gen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low and stay low until an accepted start.
- R2: An accepted start (`start_i` high at a clock edge) gives `valid_o` low at that edge. From the next edge on, `valid_o` is high for exactly K consecutive cycles, one address per cycle, and then low.
- R3: With `mode_i` = 0, output number k (counting from 0) is the address P(floor(k/R)) + 32·(k mod R), where R = K/32.
- R4: With `mode_i` = 1, output number k is (P(floor(k/R)) + 32·(k mod R) + 1) mod K. The final output of a block is therefore address 0.
- R5: P(j) is the 5-bit bit reversal of j. For example P(0..5) = 0,16,8,24,4,20 and P(31) = 31. For K = 128 in mode 0, the first outputs are 0,32,64,96,16,48,80,112.
- R6: `last_o` is high exactly on output K−1 of a block and never while `valid_o` is low.
- R7: A start accepted while a block is running abandons it. `valid_o` is low at the restart edge, and the new block then runs in full with the new K and mode.
- R8: A start whose `blk_len_i` is not a nonzero multiple of 32, or is above 32·192 = 6144, is ignored. It neither starts output when idle nor disturbs a running block.
- R9: Every address issued with `valid_o` high is below the latched K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches block length and mode |
| mode_i | input | 1 | 0: systematic/first parity order; 1: second parity order (+1 mod K) |
| blk_len_i | input | 13 | Block length K, a multiple of 32 from 32 to 6144 |
| addr_o | output | 13 | Storage address of the current output bit |
| valid_o | output | 1 | addr_o holds a valid address |
| last_o | output | 1 | Current address is the final one of the block |

## Verification
A wrong row or column counter shows as a wrong address within one cycle of the fault. It also moves the end of the block, so the count of valid cycles and the position of `last_o` both change. A wrong bit reversal first shows at output R, when the column advances. A faulty modulo stage in the second mode shows only on the final output, which must wrap to 0. The bench therefore compares every address of complete blocks for small, odd-row, and maximum K in both modes.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
    localparam int SBI_COLS     = 32;
    localparam int SBI_ROWS_MAX = 192;

    typedef enum logic {
        ORDER_PLAIN   = 1'b0,
        ORDER_SHIFTED = 1'b1
    } sbi_order_e;
endpackage

// File: rtl/sbi_bitrev.sv
module sbi_bitrev #(
    parameter int W = 5
) (
    input  logic [W-1:0] idx_i,
    output logic [W-1:0] rev_o
);
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_o[i] = idx_i[W-1-i];
    end
endmodule

// File: rtl/sbi_modk.sv
module sbi_modk #(
    parameter int W = 13
) (
    input  logic [W:0]   val_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] res_o
);
    logic [W:0] diff;

    always_comb begin
        diff  = val_i - {1'b0, mod_i};
        res_o = W'((val_i >= {1'b0, mod_i}) ? diff : val_i);
    end

    always_comb begin
        if (mod_i != '0 && val_i < {mod_i, 1'b0}) begin
            AST_MODK_RANGE: assert (res_o < mod_i); // R4
        end
    end
endmodule

// File: rtl/sbi_seq.sv
module sbi_seq #(
    parameter int COL_W = 5,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [ROW_W-1:0] rows_i,
    output logic             act_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             end_o
);
    typedef struct packed {
        logic             act;
        logic [ROW_W-1:0] rows;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic row_wrap;
    logic col_wrap;

    always_comb begin
        nxt_d    = cur_q;
        row_wrap = (cur_q.row == cur_q.rows - ROW_W'(1));
        col_wrap = (cur_q.col == '1);
        if (launch_i) begin
            nxt_d.act  = 1'b1;
            nxt_d.rows = rows_i;
            nxt_d.row  = '0;
            nxt_d.col  = '0;
        end else if (cur_q.act) begin
            if (row_wrap) begin
                nxt_d.row = '0;
                if (col_wrap) begin
                    nxt_d.act = 1'b0;
                end else begin
                    nxt_d.col = cur_q.col + COL_W'(1);
                end
            end else begin
                nxt_d.row = cur_q.row + ROW_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign act_o = cur_q.act;
    assign row_o = cur_q.row;
    assign col_o = cur_q.col;
    assign end_o = cur_q.act && row_wrap && col_wrap;

    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.act |-> (cur_q.row < cur_q.rows)); // R2
    AST_ROWS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.act |-> (cur_q.rows != '0)); // R8
endmodule

// File: rtl/sbi_addr_gen.sv
module sbi_addr_gen #(
    parameter int COLS     = sbi_pkg::SBI_COLS,
    parameter int ROWS_MAX = sbi_pkg::SBI_ROWS_MAX,
    parameter int LEN_W    = $clog2(ROWS_MAX * COLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [LEN_W-1:0] blk_len_i,
    output logic [LEN_W-1:0] addr_o,
    output logic             valid_o,
    output logic             last_o
);
    import sbi_pkg::*;

    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS_MAX);

    typedef struct packed {
        sbi_order_e       order;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] addr;
        logic             vld;
        logic             lst;
    } top_t;

    top_t cur_q, nxt_d;

    logic [LEN_W-1:0] rows_full;
    logic             len_ok;
    logic             launch;
    logic             seq_act;
    logic             seq_end;
    logic [ROW_W-1:0] seq_row;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] col_rev;
    logic [LEN_W:0]   raw_addr;
    logic [LEN_W-1:0] wrap_addr;

    always_comb begin
        rows_full = blk_len_i >> COL_W;
        len_ok    = (blk_len_i[COL_W-1:0] == '0) && (rows_full != '0)
                    && (rows_full <= LEN_W'(ROWS_MAX));
        launch    = start_i && len_ok;
    end

    sbi_seq #(
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .rows_i   (ROW_W'(rows_full)),
        .act_o    (seq_act),
        .row_o    (seq_row),
        .col_o    (seq_col),
        .end_o    (seq_end)
    );

    sbi_bitrev #(
        .W (COL_W)
    ) u_rev (
        .idx_i (seq_col),
        .rev_o (col_rev)
    );

    always_comb begin
        raw_addr = (LEN_W+1)'({seq_row, col_rev})
                   + (LEN_W+1)'(cur_q.order == ORDER_SHIFTED);
    end

    sbi_modk #(
        .W (LEN_W)
    ) u_modk (
        .val_i (raw_addr),
        .mod_i (cur_q.len),
        .res_o (wrap_addr)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.vld  = seq_act && !launch;
        nxt_d.lst  = seq_end && !launch;
        nxt_d.addr = wrap_addr;
        if (launch) begin
            nxt_d.len   = blk_len_i;
            nxt_d.order = sbi_order_e'(mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign addr_o  = cur_q.addr;
    assign valid_o = cur_q.vld;
    assign last_o  = cur_q.lst;

    AST_ADDR_BELOW_K: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (addr_o < cur_q.len)); // R9
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R6
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i) |=> valid_o); // R2
    AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o); // R2
    AST_BAD_START_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !len_ok && !valid_o && !seq_act) |=> !valid_o); // R8
endmodule

// File: tb/sbi_addr_gen_tb.sv
module sbi_addr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [12:0] blk_len_i = '0;
    logic [12:0] addr_o;
    logic        valid_o;
    logic        last_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbi_addr_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .blk_len_i (blk_len_i),
        .addr_o    (addr_o),
        .valid_o   (valid_o),
        .last_o    (last_o)
    );

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rev5(input int j);
        int r = 0;
        for (int b = 0; b < 5; b++) if (j[b]) r |= (1 << (4 - b));
        return r;
    endfunction

    function automatic int model(input int k, input int len, input int md);
        int rows = len / 32;
        int a = rev5(k / rows) + 32 * (k % rows);
        if (md != 0) a = (a + 1) % len;
        return a;
    endfunction

    // start pulse over one edge; returns at the negedge after that edge
    task automatic kick(input int len, input int md);
        start_i = 1'b1;
        blk_len_i = 13'(len);
        mode_i = md[0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // R2 R3 R4 R6: full block check; inj >= 0 pulses a bad start after that output
    task automatic expect_seq(input int len, input int md, input int inj);
        string rq = (md != 0) ? "R4" : "R3";
        chk("R2 valid low at start edge", valid_o == 1'b0, valid_o, 0);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            chk("R2 valid during block", valid_o == 1'b1, valid_o, 1);
            chk(rq, int'(addr_o) == model(k, len, md), addr_o, model(k, len, md));
            chk("R6 last position", last_o == (k == len - 1), last_o, k == len - 1);
            if (k == inj) begin
                start_i = 1'b1;
                blk_len_i = 13'd40;
            end
        end
        @(negedge clk);
        chk("R2 valid low after block", valid_o == 1'b0, valid_o, 0);
        chk("R6 last low after block", last_o == 1'b0, last_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 valid at reset", valid_o == 1'b0, valid_o, 0);
        chk("R1 last at reset", last_o == 1'b0, last_o, 0);
        repeat (3) @(negedge clk);
        chk("R1 valid idle", valid_o == 1'b0, valid_o, 0);
    endtask

    task automatic t_known_values();
        int exp[8] = '{0, 32, 64, 96, 16, 48, 80, 112};
        kick(128, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R5 K=128 prefix", int'(addr_o) == exp[k], addr_o, exp[k]);
        end
        repeat (128) @(negedge clk);
        chk("R5 bitrev 31", rev5(31) == 31 && rev5(1) == 16, rev5(1), 16);
    endtask

    task automatic t_runs();
        int lens[4] = '{32, 128, 1056, 6144};
        for (int i = 0; i < 4; i++) begin
            for (int md = 0; md < 2; md++) begin
                kick(lens[i], md);
                expect_seq(lens[i], md, -1);
            end
        end
    endtask

    task automatic t_restart();
        kick(256, 0);
        repeat (10) @(negedge clk);
        chk("R7 first block running", valid_o == 1'b1, valid_o, 1);
        kick(64, 1);
        chk("R7 valid low at restart", valid_o == 1'b0, valid_o, 0);
        expect_seq(64, 1, -1);
    endtask

    task automatic t_bad_start();
        int badlens[3] = '{40, 6176, 0};
        for (int i = 0; i < 3; i++) begin
            kick(badlens[i], 0);
            repeat (3) begin
                @(negedge clk);
                chk("R8 ignored while idle", valid_o == 1'b0, valid_o, 0);
            end
        end
        kick(128, 0);
        expect_seq(128, 0, 5);
        chk("R8 running block kept", 1'b1, 0, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_values();
        t_runs();
        t_restart();
        t_bad_start();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule